// File: doc/BRIEF.md
# Quasi-Bidirectional Port Bit Array

This block holds the output latches and pad-control logic for four 8-bit general-purpose I/O ports of a small microcontroller core. The CPU writes a port latch over the internal bus, and can read back either what it last wrote (the latch) or the level actually present at the pins. A pin whose latch holds 1 stops pulling low and can be used as an input. On ports 1 to 3 a weak pull-up then keeps it high unless an outside source pulls it down. Port 0 is open-drain, so such a pin floats.

Two ports are borrowed during external memory cycles. While bus mode is active, port 0 drives the multiplexed low address/data byte and floats when the bus reads data. Port 2 drives the high address byte. Port 2's latch comes through a bus cycle untouched. Port 0's latch is reloaded with all ones when each bus cycle starts, so the port is released as an input when bus mode ends. Port 3 combines each latch bit with an alternate-function output from an on-chip peripheral, so the pin follows that output whenever the latch bit is 1.

Pads are modelled as logic only. Each pin has a drive-low enable and a pull-up flag. The flag marks a weak pull-up, or a strong high while port 0 drives the bus. Whatever sits outside the chip resolves these into a pin level and returns it on the pin inputs.

Top module: `io_port_array`

## Requirements
- R1: After reset every latch holds FFh, no pin drive-low enable is set, and reading any latch returns FFh.
- R2: A write with wr_en_i high loads wr_data_i into the latch of port wr_port_i (0 to 3) at the clock edge and leaves the other three latches unchanged.
- R3: A read request (rd_en_i high) raises rd_valid_o for exactly one cycle at the following clock edge. With rd_pin_sel_i = 0, rd_data_o carries the latch of port rd_port_i as it stood at the request edge.
- R4: With rd_pin_sel_i = 1, rd_data_o carries the pin_i levels of port rd_port_i sampled at the request edge. These differ from the latch where a pin is pulled low from outside.
- R5: Outside bus mode and apart from port 3's alternate function, a latch bit of 0 sets that pin's drive-low enable and a latch bit of 1 clears it.
- R6: Ports 1, 2 and 3 always report a pull-up (pin_pu_o bits set). Port 0 reports none outside bus mode, so its released pins float.
- R7: In bus mode, when bus_ad_drv_i = 1 port 0 drives bus_ad_i: drive-low on its 0 bits and pull-up flags all set. When bus_ad_drv_i = 0 port 0 neither drives low nor pulls up.
- R8: In bus mode port 2 drives low exactly the 0 bits of bus_addr_hi_i, and its latch keeps its value through the bus cycle.
- R9: A bus_start_i pulse loads FFh into port 0's latch. It wins over a CPU write to port 0 in the same cycle.
- R10: On port 3 a pin drives low when its latch bit or its alt_out_i bit is 0, and is released only when both are 1.
- R11: Bus mode has no effect on the pins of ports 1 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Latch write strobe |
| wr_port_i | input | 2 | Port selected for the write |
| wr_data_i | input | 8 | Internal-bus write data |
| rd_en_i | input | 1 | Read request |
| rd_port_i | input | 2 | Port selected for the read |
| rd_pin_sel_i | input | 1 | 0 reads the latch, 1 reads the pins |
| rd_valid_o | output | 1 | Read data valid, one cycle after the request |
| rd_data_o | output | 8 | Read data |
| bus_mode_i | input | 1 | External memory bus cycle in progress |
| bus_start_i | input | 1 | First cycle of an external bus cycle |
| bus_ad_drv_i | input | 1 | Port 0 drives address/data (0: bus read, port floats) |
| bus_ad_i | input | 8 | Low address or write data for port 0 |
| bus_addr_hi_i | input | 8 | High address byte for port 2 |
| alt_out_i | input | 8 | Alternate-function outputs for port 3 |
| pin_i | input | 32 | Resolved pin levels, port k at bits 8k+7..8k |
| pin_dl_o | output | 32 | Drive-low enables, same layout |
| pin_pu_o | output | 32 | Pull-up or drive-high flags, same layout |

## Verification
The assertions assume that bus_start_i only pulses while bus_mode_i is high. They also assume that the pin levels seen on pin_i come from the block's own drive outputs plus outside pull-downs, so a pin with its drive-low enable set always reads 0. The bench guarantees both by building pin_i from the block's outputs through a weak-high model with per-pin outside pull-downs and a selectable level for floating pins. It raises bus_start_i only inside a bus-mode window. Writes and reads start on a falling edge and last one cycle, so a request never overlaps the next one.

// File: rtl/io_port_pkg.sv
package io_port_pkg;

  typedef enum logic [1:0] {
    LANE_OPEN_AD  = 2'd0,  // open drain, carries address/data in bus mode
    LANE_QUASI    = 2'd1,  // plain weak pull-up port
    LANE_ADDR_HI  = 2'd2,  // pull-up port, carries high address in bus mode
    LANE_ALT_FUNC = 2'd3   // pull-up port, merged with alternate outputs
  } lane_kind_e;

  function automatic lane_kind_e kind_of(input int idx);
    case (idx)
      0:       return LANE_OPEN_AD;
      2:       return LANE_ADDR_HI;
      3:       return LANE_ALT_FUNC;
      default: return LANE_QUASI;
    endcase
  endfunction

endpackage

// File: rtl/io_port_lane.sv
module io_port_lane
  import io_port_pkg::*;
#(
  parameter int         W    = 8,
  parameter lane_kind_e KIND = LANE_QUASI
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         load_ff_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         bus_i,
  input  logic         bus_drv_i,
  input  logic [W-1:0] bus_val_i,
  input  logic [W-1:0] alt_i,
  output logic [W-1:0] lat_o,
  output logic [W-1:0] dl_o,
  output logic [W-1:0] pu_o
);

  logic [W-1:0] lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lat_q <= '1;
    else if (load_ff_i) lat_q <= '1;
    else if (wr_i)      lat_q <= wr_data_i;
  end

  assign lat_o = lat_q;

  generate
    if (KIND == LANE_OPEN_AD) begin : g_open_ad
      always_comb begin
        if (bus_i) begin
          dl_o = bus_drv_i ? ~bus_val_i : '0;
          pu_o = bus_drv_i ? '1 : '0;
        end else begin
          dl_o = ~lat_q;
          pu_o = '0;
        end
      end
    end else if (KIND == LANE_ADDR_HI) begin : g_addr_hi
      assign dl_o = bus_i ? ~bus_val_i : ~lat_q;
      assign pu_o = '1;
    end else if (KIND == LANE_ALT_FUNC) begin : g_alt
      assign dl_o = ~(lat_q & alt_i);
      assign pu_o = '1;
    end else begin : g_quasi
      assign dl_o = ~lat_q;
      assign pu_o = '1;
    end
  endgenerate

  logic unused_ok;
  assign unused_ok = ^{alt_i, bus_val_i, bus_drv_i, bus_i};

  // R2
  wr_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !load_ff_i) |=> (lat_q == $past(wr_data_i)));

  // R9
  bus_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_ff_i |=> (lat_q == '1));

  // R8
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !load_ff_i) |=> $stable(lat_q));

endmodule

// File: rtl/io_port_rd_mux.sv
module io_port_rd_mux #(
  parameter int NUM_PORTS = 4,
  parameter int W         = 8,
  localparam int PSEL_W   = $clog2(NUM_PORTS),
  localparam int ALL_W    = NUM_PORTS * W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [PSEL_W-1:0] rd_port_i,
  input  logic              rd_pin_sel_i,
  input  logic [ALL_W-1:0]  lat_i,
  input  logic [ALL_W-1:0]  pin_i,
  output logic              rd_valid_o,
  output logic [W-1:0]      rd_data_o
);

  logic [W-1:0] sel_lat, sel_pin;

  assign sel_lat = lat_i[rd_port_i*W +: W];
  assign sel_pin = pin_i[rd_port_i*W +: W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= rd_pin_sel_i ? sel_pin : sel_lat;
    end
  end

  // R3
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);

  // R3
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);

  // R3
  rd_latch_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_pin_sel_i) |=> (rd_data_o == $past(lat_i[rd_port_i*W +: W])));

  // R4
  rd_pin_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_pin_sel_i) |=> (rd_data_o == $past(pin_i[rd_port_i*W +: W])));

endmodule

// File: rtl/io_port_array.sv
module io_port_array
  import io_port_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 8,
  localparam int PSEL_W   = $clog2(NUM_PORTS),
  localparam int ALL_W    = NUM_PORTS * PORT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PSEL_W-1:0] wr_port_i,
  input  logic [PORT_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [PSEL_W-1:0] rd_port_i,
  input  logic              rd_pin_sel_i,
  output logic              rd_valid_o,
  output logic [PORT_W-1:0] rd_data_o,
  input  logic              bus_mode_i,
  input  logic              bus_start_i,
  input  logic              bus_ad_drv_i,
  input  logic [PORT_W-1:0] bus_ad_i,
  input  logic [PORT_W-1:0] bus_addr_hi_i,
  input  logic [PORT_W-1:0] alt_out_i,
  input  logic [ALL_W-1:0]  pin_i,
  output logic [ALL_W-1:0]  pin_dl_o,
  output logic [ALL_W-1:0]  pin_pu_o
);

  logic [ALL_W-1:0] lat_all;

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
    localparam lane_kind_e KIND = kind_of(k);
    logic              wr_sel;
    logic              load_ff;
    logic [PORT_W-1:0] bus_val;

    assign wr_sel  = wr_en_i && (wr_port_i == PSEL_W'(k));
    assign load_ff = (KIND == LANE_OPEN_AD) && bus_start_i;
    assign bus_val = (KIND == LANE_OPEN_AD) ? bus_ad_i : bus_addr_hi_i;

    io_port_lane #(
      .W    (PORT_W),
      .KIND (KIND)
    ) u_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (wr_sel),
      .load_ff_i (load_ff),
      .wr_data_i (wr_data_i),
      .bus_i     (bus_mode_i),
      .bus_drv_i (bus_ad_drv_i),
      .bus_val_i (bus_val),
      .alt_i     (alt_out_i),
      .lat_o     (lat_all[k*PORT_W +: PORT_W]),
      .dl_o      (pin_dl_o[k*PORT_W +: PORT_W]),
      .pu_o      (pin_pu_o[k*PORT_W +: PORT_W])
    );
  end

  io_port_rd_mux #(
    .NUM_PORTS (NUM_PORTS),
    .W         (PORT_W)
  ) u_rd_mux (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_en_i      (rd_en_i),
    .rd_port_i    (rd_port_i),
    .rd_pin_sel_i (rd_pin_sel_i),
    .lat_i        (lat_all),
    .pin_i        (pin_i),
    .rd_valid_o   (rd_valid_o),
    .rd_data_o    (rd_data_o)
  );

  // R5: a pin that drives low must read low
  driven_low_reads_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_dl_o & pin_i) == '0));

  // R9: bus cycles start only inside bus mode
  start_in_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_start_i |-> bus_mode_i);

endmodule

// File: tb/io_port_array_tb.sv
`timescale 1ns/1ps
module io_port_array_tb;

  localparam int NP = 4;
  localparam int W  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_port = '0;
  logic [W-1:0]  wr_data = '0;
  logic          rd_en = 1'b0;
  logic [1:0]    rd_port = '0;
  logic          rd_pin_sel = 1'b0;
  logic          rd_valid;
  logic [W-1:0]  rd_data;
  logic          bus_mode = 1'b0;
  logic          bus_start = 1'b0;
  logic          bus_ad_drv = 1'b0;
  logic [W-1:0]  bus_ad = '0;
  logic [W-1:0]  bus_hi = '0;
  logic [W-1:0]  alt_out = '1;
  logic [NP*W-1:0] pin, dl, pu;
  logic [NP*W-1:0] ext_low = '0;
  logic          float_lvl = 1'b1;

  always #2.5 clk = ~clk;

  io_port_array u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_port_i(wr_port), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_port_i(rd_port), .rd_pin_sel_i(rd_pin_sel),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .bus_mode_i(bus_mode), .bus_start_i(bus_start), .bus_ad_drv_i(bus_ad_drv),
    .bus_ad_i(bus_ad), .bus_addr_hi_i(bus_hi), .alt_out_i(alt_out),
    .pin_i(pin), .pin_dl_o(dl), .pin_pu_o(pu)
  );

  // weak-high pad model
  always_comb begin
    for (int i = 0; i < NP*W; i++)
      pin[i] = dl[i] ? 1'b0 : (ext_low[i] ? 1'b0 : (pu[i] ? 1'b1 : float_lvl));
  end

  int total = 0;
  int bad = 0;
  logic [W-1:0] mdl_lat [NP];

  typedef struct { logic [W-1:0] exp; string tag; } sb_item_t;
  sb_item_t sb_q[$];

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // expected drive-low / pull-up from the bench's own model
  function automatic logic [W-1:0] exp_dl(input int p);
    if (p == 0) return bus_mode ? (bus_ad_drv ? ~bus_ad : 8'h00) : ~mdl_lat[0];
    if (p == 2) return bus_mode ? ~bus_hi : ~mdl_lat[2];
    if (p == 3) return ~(mdl_lat[3] & alt_out);
    return ~mdl_lat[p];
  endfunction

  function automatic logic [W-1:0] exp_pu(input int p);
    if (p == 0) return (bus_mode && bus_ad_drv) ? 8'hFF : 8'h00;
    return 8'hFF;
  endfunction

  function automatic logic [W-1:0] exp_pin(input int p);
    logic [W-1:0] d, u, e, r;
    d = exp_dl(p); u = exp_pu(p); e = ext_low[p*W +: W];
    for (int b = 0; b < W; b++)
      r[b] = d[b] ? 1'b0 : (e[b] ? 1'b0 : (u[b] ? 1'b1 : float_lvl));
    return r;
  endfunction

  task automatic wr(input int p, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_port = 2'(p); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    mdl_lat[p] = d;
  endtask

  task automatic rd(input int p, input logic sel, input string tag);
    sb_item_t it;
    @(negedge clk);
    it.exp = sel ? exp_pin(p) : mdl_lat[p];
    it.tag = tag;
    sb_q.push_back(it);
    rd_en = 1'b1; rd_port = 2'(p); rd_pin_sel = sel;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk_pins(input int p, input string tag);
    check({tag, " dl"}, dl[p*W +: W], exp_dl(p));
    check({tag, " pu"}, pu[p*W +: W], exp_pu(p));
  endtask

  // monitor: pops expected items as reads complete
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (sb_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R3 unexpected rd_valid act=%h exp=none", rd_data);
      end else begin
        sb_item_t it;
        it = sb_q.pop_front();
        check(it.tag, rd_data, it.exp);
      end
    end
  end

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) mdl_lat[p] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R6 reset state
    for (int p = 0; p < NP; p++) begin
      check("R1 reset dl", dl[p*W +: W], 8'h00);
      check("R6 reset pu", pu[p*W +: W], (p == 0) ? 8'h00 : 8'hFF);
      rd(p, 1'b0, "R1 reset latch read");
    end

    // R2 / R5 writes, one port at a time
    wr(1, 8'hA5);
    check("R2 other port untouched p0", dl[0 +: W], 8'h00);
    check("R2 other port untouched p2", dl[16 +: W], 8'h00);
    chk_pins(1, "R5 p1");
    wr(0, 8'h3C);
    wr(2, 8'h0F);
    wr(3, 8'hF0);
    for (int p = 0; p < NP; p++) begin
      chk_pins(p, "R5 after writes");
      rd(p, 1'b0, "R2 R3 latch read");
    end

    // R4 pin read differs from latch when pulled low outside
    ext_low[8 +: W] = 8'h21;
    @(negedge clk);
    rd(1, 1'b1, "R4 p1 pin read");
    rd(1, 1'b0, "R4 p1 latch read");
    ext_low = '0;

    // R6 port 0 floats: released bits follow float level
    float_lvl = 1'b0;
    rd(0, 1'b1, "R6 p0 float low");
    float_lvl = 1'b1;
    rd(0, 1'b1, "R6 p0 float high");

    // R10 alternate function on port 3
    alt_out = 8'hAA;
    @(negedge clk);
    chk_pins(3, "R10 alt");
    rd(3, 1'b1, "R10 p3 pin read");
    alt_out = 8'hFF;

    // R7 R8 R11 bus mode
    @(negedge clk);
    bus_mode = 1'b1; bus_start = 1'b1; bus_ad_drv = 1'b1;
    bus_ad = 8'h34; bus_hi = 8'h12;
    @(negedge clk);
    bus_start = 1'b0;
    mdl_lat[0] = 8'hFF;
    chk_pins(0, "R7 p0 drive");
    chk_pins(2, "R8 p2 addr");
    chk_pins(1, "R11 p1 in bus");
    chk_pins(3, "R11 p3 in bus");
    bus_ad_drv = 1'b0;
    @(negedge clk);
    chk_pins(0, "R7 p0 bus read float");
    rd(2, 1'b0, "R8 p2 latch during bus");
    @(negedge clk);
    bus_mode = 1'b0;
    @(negedge clk);
    chk_pins(2, "R8 p2 after bus");
    chk_pins(0, "R9 p0 released");
    rd(2, 1'b0, "R8 p2 latch after bus");
    rd(0, 1'b0, "R9 p0 latch reloaded");

    // R9 bus start beats same-cycle write
    wr(0, 8'h55);
    @(negedge clk);
    bus_mode = 1'b1;
    wr_en = 1'b1; wr_port = 2'd0; wr_data = 8'h00; bus_start = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; bus_start = 1'b0; bus_mode = 1'b0;
    mdl_lat[0] = 8'hFF;
    rd(0, 1'b0, "R9 start over write");

    repeat (4) @(negedge clk);
    check("R3 scoreboard drained", 8'(sb_q.size()), 8'h00);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule